// File: doc/BRIEF.md
# Carrier and Collision Activity Squelch

This block qualifies two oversampled line-activity indications before the rest of a network receiver acts on them. One channel takes the digitised output of the receive-activity comparator and produces a carrier-present flag. The other channel takes the digitised output of the collision comparator and produces a collision flag. The analog thresholds sit outside the block; it sees only one-bit samples taken on its clock.

Each channel holds its output until the input has shown the opposite level for a minimum number of consecutive samples. The number required to turn on and the number required to turn off are separate parameters, so short noise spikes are rejected while an output is low. Once an output is high, brief dips, such as the mid-bit gaps of Manchester data, do not clear it. Any run that ends early restarts the count. At the default 100 MHz sample clock, the carrier channel needs 2 samples to turn on and 16 samples to turn off. The collision channel needs 1 sample to turn on and 2 samples to turn off. Each input passes through one sampling register before qualification.

Top module: `line_activity_squelch`

## Requirements
- R1: After reset, and while both inputs stay low, `carrier_o` and `collision_o` are 0.
- R2: A high run on `rx_energy_i` shorter than CRS_ON_W (default 2) samples never sets `carrier_o`. A one-sample pulse leaves it at 0.
- R3: If `rx_energy_i` rises after rising edge k and stays high, `carrier_o` becomes 1 at edge k+CRS_ON_W+1. It is still 0 at edge k+CRS_ON_W.
- R4: With COL_ON_W = 1, a one-sample high pulse on `col_energy_i` sets `collision_o` at edge k+2. It clears it COL_OFF_W+1 edges after the input falls.
- R5: While `carrier_o` is 1, a low run on `rx_energy_i` shorter than CRS_OFF_W (default 16) samples keeps it at 1. A low run that holds from edge k clears it at edge k+CRS_OFF_W+1.
- R6: A qualifying run restarts from zero whenever the input returns to the current output level. Interrupted runs never add up. Alternating one-sample highs do not set carrier. Two 10-sample carrier gaps split by one high sample do not clear it.
- R7: Each channel ignores the other channel's input. `col_energy_i` has no effect on `carrier_o`, and `rx_energy_i` has no effect on `collision_o`.
- R8: While `collision_o` is 1, a low run on `col_energy_i` shorter than COL_OFF_W (default 2) samples keeps it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_energy_i | input | 1 | Receive-activity comparator sample, 1 = activity |
| col_energy_i | input | 1 | Collision comparator sample, 1 = activity |
| carrier_o | output | 1 | Qualified carrier present, registered |
| collision_o | output | 1 | Qualified collision flag, registered |

## Verification
The assertions take both inputs as already synchronous to `clk`, changing only between rising edges. The bench respects this by driving every input on the falling edge. The assertions also expect reset to be held for at least one edge so that the counters and the sampling stage start cleared. The stimulus holds reset for several cycles. It then uses only whole-cycle pulses and gaps of chosen lengths, placed just below and at each width parameter.

// File: rtl/squelch_pkg.sv
package squelch_pkg;

    typedef enum logic {
        LINE_QUIET = 1'b0,
        LINE_BUSY  = 1'b1
    } line_state_e;

    // Bits needed for a run counter that counts 0 .. max(on_w, off_w)-1
    function automatic int run_bits(input int on_w, input int off_w);
        int widest;
        widest = (on_w > off_w) ? on_w : off_w;
        return (widest <= 2) ? 1 : $clog2(widest);
    endfunction

endpackage

// File: rtl/activity_sampler.sv
module activity_sampler #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic smp_o
);

    logic [STAGES-1:0] pipe_d, pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb pipe_d = raw_i;
        end else begin : g_chain
            always_comb pipe_d = {pipe_q[STAGES-2:0], raw_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign smp_o = pipe_q[STAGES-1];

endmodule

// File: rtl/pulse_width_qualifier.sv
module pulse_width_qualifier
    import squelch_pkg::*;
#(
    parameter int ON_W  = 2,
    parameter int OFF_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_i,
    output logic active_o
);

    localparam int            CW      = run_bits(ON_W, OFF_W);
    localparam logic [CW-1:0] ON_LIM  = CW'(ON_W - 1);
    localparam logic [CW-1:0] OFF_LIM = CW'(OFF_W - 1);
    localparam logic [CW-1:0] RUN_MAX = (ON_LIM > OFF_LIM) ? ON_LIM : OFF_LIM;

    typedef struct packed {
        line_state_e   state;
        logic [CW-1:0] run;
    } qual_t;

    qual_t         cur_q, nxt_d;
    logic [CW-1:0] lim_d;
    logic          busy_d;
    logic          differs_d;

    always_comb begin
        nxt_d     = cur_q;
        busy_d    = (cur_q.state == LINE_BUSY);
        lim_d     = busy_d ? OFF_LIM : ON_LIM;
        differs_d = (smp_i != busy_d);
        if (!differs_d) begin
            nxt_d.run = '0;
        end else if (cur_q.run == lim_d) begin
            nxt_d.run   = '0;
            nxt_d.state = busy_d ? LINE_QUIET : LINE_BUSY;
        end else begin
            nxt_d.run = cur_q.run + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{state: LINE_QUIET, run: '0};
        else        cur_q <= nxt_d;
    end

    assign active_o = (cur_q.state == LINE_BUSY);

    // R3
    rise_needs_busy_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> $past(smp_i));

    // R5
    fall_needs_quiet_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> !$past(smp_i));

    // R6
    run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_i == active_o) |=> (cur_q.run == '0));

    // R6
    run_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.run <= RUN_MAX);

endmodule

// File: rtl/squelch_channel.sv
module squelch_channel #(
    parameter int ON_W   = 2,
    parameter int OFF_W  = 16,
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic active_o
);

    logic smp;

    activity_sampler #(.STAGES(STAGES)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw_i),
        .smp_o (smp)
    );

    pulse_width_qualifier #(.ON_W(ON_W), .OFF_W(OFF_W)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_i    (smp),
        .active_o (active_o)
    );

endmodule

// File: rtl/line_activity_squelch.sv
module line_activity_squelch #(
    parameter int CRS_ON_W      = 2,
    parameter int CRS_OFF_W     = 16,
    parameter int COL_ON_W      = 1,
    parameter int COL_OFF_W     = 2,
    parameter int SAMPLE_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_energy_i,
    input  logic col_energy_i,
    output logic carrier_o,
    output logic collision_o
);

    localparam int NCH = 2;
    localparam int ON_TBL  [NCH] = '{CRS_ON_W,  COL_ON_W};
    localparam int OFF_TBL [NCH] = '{CRS_OFF_W, COL_OFF_W};

    logic [NCH-1:0] raw_vec;
    logic [NCH-1:0] act_vec;

    assign raw_vec = {col_energy_i, rx_energy_i};

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            squelch_channel #(
                .ON_W   (ON_TBL[g]),
                .OFF_W  (OFF_TBL[g]),
                .STAGES (SAMPLE_STAGES)
            ) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .raw_i    (raw_vec[g]),
                .active_o (act_vec[g])
            );
        end
    endgenerate

    assign carrier_o   = act_vec[0];
    assign collision_o = act_vec[1];

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!carrier_o && !collision_o));

endmodule

// File: tb/line_activity_squelch_bench.sv
module line_activity_squelch_bench;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_energy_i = 1'b0;
    logic col_energy_i = 1'b0;
    logic carrier_o, collision_o;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    chan;   // 0 = carrier, 1 = collision
        bit    val;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    line_activity_squelch u_line_activity_squelch (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_energy_i  (rx_energy_i),
        .col_energy_i (col_energy_i),
        .carrier_o    (carrier_o),
        .collision_o  (collision_o)
    );

    // driver helpers: drive at a falling edge, expectations relative to it
    task automatic drive(input bit r, input bit c);
        @(negedge clk);
        rx_energy_i  = r;
        col_energy_i = c;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int ofs, input bit chan, input bit val, input string tag);
        exp_t e;
        e.at = cyc + ofs; e.chan = chan; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: pop and compare items that fall due at this falling edge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at <= cyc) begin
                bit act;
                act = sb[i].chan ? collision_o : carrier_o;
                n_tests++;
                if (sb[i].at != cyc || act !== sb[i].val) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d %s actual=%b expected=%b",
                             sb[i].tag, cyc, sb[i].chan ? "collision" : "carrier",
                             act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(4);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        for (int k = 1; k <= 4; k++) begin
            expect_at(k, 0, 0, "R1");
            expect_at(k, 1, 0, "R1");
        end
        idle(8);

        // R2: one-sample carrier glitch rejected
        drive(1, 0);
        for (int k = 1; k <= 6; k++) expect_at(k, 0, 0, "R2");
        drive(0, 0);
        idle(10);

        // R3: on latency = CRS_ON_W + 1 edges; R7 collision untouched
        drive(1, 0);
        expect_at(2, 0, 0, "R3");
        expect_at(3, 0, 1, "R3");
        expect_at(3, 1, 0, "R7");
        idle(10);

        // R5: 15-sample gap keeps carrier
        drive(0, 0);
        expect_at(1, 0, 1, "R5");
        expect_at(16, 0, 1, "R5");
        expect_at(20, 0, 1, "R5");
        idle(14);
        drive(1, 0);
        idle(10);

        // R6: two 10-sample gaps split by one high sample keep carrier
        drive(0, 0);
        expect_at(17, 0, 1, "R6");
        expect_at(21, 0, 1, "R6");
        idle(9);
        drive(1, 0);
        drive(0, 0);
        // R5: full gap clears carrier at CRS_OFF_W + 1 edges
        expect_at(16, 0, 1, "R5");
        expect_at(17, 0, 0, "R5");
        idle(25);

        // R6: alternating one-sample highs never set carrier
        for (int k = 0; k < 6; k++) begin
            drive(1, 0);
            expect_at(1, 0, 0, "R6");
            expect_at(2, 0, 0, "R6");
            drive(0, 0);
        end
        idle(10);

        // R4: one-sample collision pulse sets flag, clears after off-width
        drive(0, 1);
        expect_at(1, 1, 0, "R4");
        expect_at(2, 1, 1, "R4");
        expect_at(2, 0, 0, "R7");
        drive(0, 0);
        expect_at(2, 1, 1, "R4");
        expect_at(3, 1, 0, "R4");
        expect_at(3, 0, 0, "R7");
        idle(10);

        // R8: one-sample gap keeps collision set
        drive(0, 1);
        idle(5);
        drive(0, 0);
        for (int k = 1; k <= 5; k++) expect_at(k, 1, 1, "R8");
        drive(0, 1);
        idle(5);

        // R7: carrier activity during collision leaves collision intact
        drive(1, 1);
        expect_at(3, 0, 1, "R3");
        for (int k = 1; k <= 6; k++) expect_at(k, 1, 1, "R7");
        idle(8);
        drive(1, 0);
        expect_at(2, 1, 1, "R4");
        expect_at(3, 1, 0, "R4");
        for (int k = 1; k <= 6; k++) expect_at(k, 0, 1, "R7");
        idle(8);
        drive(0, 0);
        expect_at(17, 0, 0, "R5");
        idle(30);

        wait (sb.size() == 0);
        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule